// File: doc/BRIEF.md
# Read Gate Sync Acquisition Controller

This block sits after the bit-level decoder of a disk read channel. It watches the stream of decoded bytes and decides when to raise a read gate, the signal that tells an external phase-lock loop to start acquiring lock on the incoming data. Each byte arrives with a one-cycle strobe. A separate detector reports when a byte closes an address mark; this block does not detect the mark pattern itself.

The search has two phases. First the block counts consecutive all-zero bytes, which make up the preamble. When enough of them have arrived, it raises the gate and opens a bounded window, counted in bytes, in which an address mark has to appear. If a mark is flagged inside the window, the block pulses a found output for one cycle and keeps the gate high for as long as the search stays enabled. If the window runs out, the block drops the gate and starts counting zeros again. The density select sets how long both phases are. Dropping the search enable sends the block back to idle at any time.

Top module: `rdgate_sync`

## Requirements
- R1: After reset, `readGate` and `markFound` are both 0.
- R2: With `denSel` = 1 (single density), `readGate` goes to 1 in the cycle after the second consecutive strobed byte of value 0x00.
- R3: With `denSel` = 0 (double density), `readGate` goes to 1 only after the fourth consecutive strobed zero byte. Three zero bytes leave it at 0.
- R4: While the gate is low, a strobed non-zero byte resets the zero-byte count, so a full run of zeros must follow it.
- R5: `byteVal` is ignored in cycles where `byteStb` is 0, so zeros held on the bus without a strobe add nothing to the count.
- R6: With `denSel` = 1, the window is 10 strobed bytes. A mark flagged with the 10th byte is accepted. If none of the 10 bytes carries a mark, `readGate` falls after the 10th and the zero count starts again from 0.
- R7: With `denSel` = 0, the window is 16 strobed bytes, with the same accept and restart rules as R6.
- R8: A byte strobed with `markHit` = 1 inside the window makes `markFound` 1 for exactly one cycle. `readGate` then stays 1, with no further pulses, until `searchEn` falls.
- R9: When `searchEn` is 0 at a clock edge, `readGate` is 0 after that edge. A later re-enable begins with a zero count of 0.
- R10: `markHit` is ignored while the gate is low. It produces no `markFound` and does not stop a zero byte from counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteStb | input | 1 | One-cycle strobe: a decoded byte is valid |
| byteVal | input | 8 | Decoded byte value |
| markHit | input | 1 | Address-mark flag, qualified by `byteStb` |
| denSel | input | 1 | 0 = double density, 1 = single density |
| searchEn | input | 1 | 1 = search runs, 0 = return to idle |
| readGate | output | 1 | Gate to the external phase-lock loop |
| markFound | output | 1 | One-cycle pulse when a mark is accepted |

## Verification
The bench builds the block with its default lengths: a 2- and 4-byte preamble and a 10- and 16-byte window. With these values, every preamble boundary, both window expiries and the last-byte mark acceptance can each be reached within a few dozen strobes. This lets the same run cover both densities, a timeout followed by a fresh preamble, and a lock held across later marks.

// File: rtl/rdgate_pkg.sv
package rdgate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HUNT   = 2'd1,
    ST_WINDOW = 2'd2,
    ST_LOCKED = 2'd3
  } syncState_t;

  typedef struct packed {
    logic clrZero;
    logic incZero;
    logic clrWin;
    logic incWin;
  } dpCmd_t;

endpackage

// File: rtl/rdgate_dp.sv
module rdgate_dp
  import rdgate_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int FM_PRE    = 2,
  parameter int MFM_PRE   = 4,
  parameter int FM_WIN    = 10,
  parameter int MFM_WIN   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              denSel,
  input  logic [BYTE_W-1:0] byteVal,
  input  dpCmd_t            cmd,
  output logic              zeroByte,
  output logic              preDone,
  output logic              winDone
);

  localparam int ZERO_MAX = (FM_PRE > MFM_PRE) ? FM_PRE : MFM_PRE;
  localparam int WIN_MAX  = (FM_WIN > MFM_WIN) ? FM_WIN : MFM_WIN;
  localparam int ZW = $clog2(ZERO_MAX + 1);
  localparam int WW = $clog2(WIN_MAX + 1);

  logic [ZW-1:0] zeroCnt;
  logic [WW-1:0] winCnt;
  logic [ZW-1:0] preLast;
  logic [WW-1:0] winLast;

  assign preLast  = denSel ? ZW'(FM_PRE - 1) : ZW'(MFM_PRE - 1);
  assign winLast  = denSel ? WW'(FM_WIN - 1) : WW'(MFM_WIN - 1);
  assign zeroByte = (byteVal == '0);
  assign preDone  = (zeroCnt >= preLast);
  assign winDone  = (winCnt >= winLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroCnt <= '0;
    end else if (cmd.clrZero) begin
      zeroCnt <= '0;
    end else if (cmd.incZero) begin
      zeroCnt <= zeroCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (cmd.clrWin) begin
      winCnt <= '0;
    end else if (cmd.incWin) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  // R3
  zero_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroCnt < ZW'(ZERO_MAX));

  // R7
  win_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    winCnt < WW'(WIN_MAX));

endmodule

// File: rtl/rdgate_ctl.sv
module rdgate_ctl
  import rdgate_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   searchEn,
  input  logic   byteStb,
  input  logic   markHit,
  input  logic   zeroByte,
  input  logic   preDone,
  input  logic   winDone,
  output dpCmd_t cmd,
  output logic   gateOn,
  output logic   foundPulse
);

  syncState_t st, nxt;
  logic hitNow;

  always_comb begin
    nxt    = st;
    cmd    = '0;
    hitNow = 1'b0;
    if (!searchEn) begin
      nxt         = ST_IDLE;
      cmd.clrZero = 1'b1;
      cmd.clrWin  = 1'b1;
    end else begin
      unique case (st)
        ST_IDLE: begin
          nxt         = ST_HUNT;
          cmd.clrZero = 1'b1;
          cmd.clrWin  = 1'b1;
        end
        ST_HUNT: begin
          if (byteStb) begin
            if (!zeroByte) begin
              cmd.clrZero = 1'b1;
            end else if (preDone) begin
              nxt         = ST_WINDOW;
              cmd.clrZero = 1'b1;
              cmd.clrWin  = 1'b1;
            end else begin
              cmd.incZero = 1'b1;
            end
          end
        end
        ST_WINDOW: begin
          if (byteStb) begin
            if (markHit) begin
              nxt    = ST_LOCKED;
              hitNow = 1'b1;
            end else if (winDone) begin
              nxt         = ST_HUNT;
              cmd.clrZero = 1'b1;
              cmd.clrWin  = 1'b1;
            end else begin
              cmd.incWin = 1'b1;
            end
          end
        end
        ST_LOCKED: nxt = ST_LOCKED;
        default:   nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      foundPulse <= 1'b0;
    end else begin
      st         <= nxt;
      foundPulse <= hitNow;
    end
  end

  assign gateOn = (st == ST_WINDOW) || (st == ST_LOCKED);

  // R8
  found_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    foundPulse |=> !foundPulse);

  // R8
  found_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    foundPulse |-> (st == ST_LOCKED));

endmodule

// File: rtl/rdgate_sync.sv
module rdgate_sync
  import rdgate_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int FM_PRE  = 2,
  parameter int MFM_PRE = 4,
  parameter int FM_WIN  = 10,
  parameter int MFM_WIN = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteStb,
  input  logic [BYTE_W-1:0] byteVal,
  input  logic              markHit,
  input  logic              denSel,
  input  logic              searchEn,
  output logic              readGate,
  output logic              markFound
);

  dpCmd_t cmd;
  logic   zeroByte;
  logic   preDone;
  logic   winDone;

  rdgate_dp #(
    .BYTE_W (BYTE_W),
    .FM_PRE (FM_PRE),
    .MFM_PRE(MFM_PRE),
    .FM_WIN (FM_WIN),
    .MFM_WIN(MFM_WIN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .denSel  (denSel),
    .byteVal (byteVal),
    .cmd     (cmd),
    .zeroByte(zeroByte),
    .preDone (preDone),
    .winDone (winDone)
  );

  rdgate_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .searchEn  (searchEn),
    .byteStb   (byteStb),
    .markHit   (markHit),
    .zeroByte  (zeroByte),
    .preDone   (preDone),
    .winDone   (winDone),
    .cmd       (cmd),
    .gateOn    (readGate),
    .foundPulse(markFound)
  );

  // R2
  gate_rise_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readGate) |-> ($past(byteStb) && ($past(byteVal) == '0) && $past(searchEn)));

  // R9
  gate_off_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !searchEn |=> !readGate);

  // R6
  gate_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readGate) |-> (!$past(searchEn) || ($past(byteStb) && !$past(markHit))));

  // R10
  found_needs_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    markFound |-> (readGate && $past(readGate)));

endmodule

// File: tb/rdgate_sync_bench.sv
module rdgate_sync_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteStb = 1'b0;
  logic [7:0] byteVal = 8'h00;
  logic       markHit = 1'b0;
  logic       denSel = 1'b1;
  logic       searchEn = 1'b0;
  logic       readGate;
  logic       markFound;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  rdgate_sync u_rdgate_sync (
    .clk      (clk),
    .rstN     (rstN),
    .byteStb  (byteStb),
    .byteVal  (byteVal),
    .markHit  (markHit),
    .denSel   (denSel),
    .searchEn (searchEn),
    .readGate (readGate),
    .markFound(markFound)
  );

  // Monitor: compares at 1 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        logic [1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if ({readGate, markFound} !== e) begin
          fails++;
          $display("FAIL %s: gate/found actual %b%b expected %b%b",
                   t, readGate, markFound, e[1], e[0]);
        end
      end
    end
  end

  task automatic expectNow(input logic g, input logic f, input string tag);
    expQ.push_back({g, f});
    tagQ.push_back(tag);
  endtask

  task automatic sendByte(input logic [7:0] v, input logic m,
                          input logic g, input logic f, input string tag);
    @(negedge clk);
    byteStb = 1'b1;
    byteVal = v;
    markHit = m;
    @(negedge clk);
    byteStb = 1'b0;
    markHit = 1'b0;
    byteVal = 8'hA5;
    expectNow(g, f, tag);
  endtask

  task automatic setEnable(input logic en);
    @(negedge clk);
    searchEn = en;
    @(negedge clk);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectNow(1'b0, 1'b0, "R1 during reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectNow(1'b0, 1'b0, "R1 after reset");

    // Single density: lock on the last byte of the window
    denSel = 1'b1;
    setEnable(1'b1);
    sendByte(8'h00, 1'b0, 1'b0, 1'b0, "R2 first zero");
    sendByte(8'h00, 1'b0, 1'b1, 1'b0, "R2 second zero");
    for (int i = 0; i < 9; i++) sendByte(8'h12, 1'b0, 1'b1, 1'b0, "R6 window open");
    sendByte(8'h12, 1'b1, 1'b1, 1'b1, "R6 mark on 10th byte");
    @(negedge clk);
    expectNow(1'b1, 1'b0, "R8 pulse one cycle");
    @(negedge clk);
    searchEn = 1'b0;
    @(negedge clk);
    expectNow(1'b0, 1'b0, "R9 gate cleared");

    // Reset of count, mark ignored in hunt, timeout
    setEnable(1'b1);
    sendByte(8'h00, 1'b0, 1'b0, 1'b0, "R9 fresh count");
    sendByte(8'h55, 1'b0, 1'b0, 1'b0, "R4 nonzero byte");
    sendByte(8'h00, 1'b0, 1'b0, 1'b0, "R4 count restarted");
    sendByte(8'h00, 1'b1, 1'b1, 1'b0, "R10 mark in hunt ignored");
    for (int i = 0; i < 9; i++) sendByte(8'h33, 1'b0, 1'b1, 1'b0, "R6 waiting");
    sendByte(8'h33, 1'b0, 1'b0, 1'b0, "R6 timeout after 10");
    sendByte(8'h00, 1'b0, 1'b0, 1'b0, "R6 hunt restarted");
    @(negedge clk);
    byteVal = 8'h00;
    repeat (4) @(negedge clk);
    expectNow(1'b0, 1'b0, "R5 unstrobed zeros");
    sendByte(8'h80, 1'b0, 1'b0, 1'b0, "R4 nonzero clears");
    sendByte(8'h00, 1'b0, 1'b0, 1'b0, "R5 count is one");
    sendByte(8'h00, 1'b0, 1'b1, 1'b0, "R5 gate after two");
    setEnable(1'b0);
    expectNow(1'b0, 1'b0, "R9 disable from window");

    // Double density
    denSel = 1'b0;
    setEnable(1'b1);
    for (int i = 0; i < 3; i++) sendByte(8'h00, 1'b0, 1'b0, 1'b0, "R3 three zeros");
    sendByte(8'h00, 1'b0, 1'b1, 1'b0, "R3 fourth zero");
    for (int i = 0; i < 15; i++) sendByte(8'h4E, 1'b0, 1'b1, 1'b0, "R7 window open");
    sendByte(8'h4E, 1'b0, 1'b0, 1'b0, "R7 timeout after 16");
    for (int i = 0; i < 3; i++) sendByte(8'h00, 1'b0, 1'b0, 1'b0, "R7 re-hunt");
    sendByte(8'h00, 1'b0, 1'b1, 1'b0, "R7 regained gate");
    for (int i = 0; i < 15; i++) sendByte(8'h4E, 1'b0, 1'b1, 1'b0, "R7 waiting");
    sendByte(8'hFE, 1'b1, 1'b1, 1'b1, "R7 mark on 16th byte");
    sendByte(8'hFE, 1'b1, 1'b1, 1'b0, "R8 no second pulse");
    for (int i = 0; i < 20; i++) sendByte(8'h4E, 1'b0, 1'b1, 1'b0, "R8 gate held");
    setEnable(1'b0);
    expectNow(1'b0, 1'b0, "R9 disable from lock");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule